// File: doc/BRIEF.md
# Key-Protected Interrupt and Reset Control Register

This block is one 32-bit memory-mapped control word for a small processor subsystem. It sits on a plain register bus with an address, a write strobe, write data and registered read data. Software must place an unlock key in the upper halfword of every write. A write without that key is dropped whole.

The word holds a 3-bit priority-grouping field and a fixed, read-only endianness flag. From the grouping field the block derives a subpriority mask for the interrupt controller. The mask gives the binary point that divides each priority value into a preemption part above it and a subpriority part below it.

Three bits of the word do not store anything. A keyed write of 1 to one of them fires a one-cycle request: a warm system reset, a clear of all active exception state, or a local core reset that spares debug logic. The core reset request is honoured only while the core reports that it is halted. The reset sequencer and the interrupt controller that act on these requests are outside this block.

Top module: `sysctl_keyreg`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `bus_rdata` and all three request outputs are 0 and `sub_mask` is 0x01. The first read of the register then returns 0xFA050000.
- R2: A write is accepted only when `bus_wr` is 1, `bus_addr` equals `REG_ADDR` (default 0xD0C), and `bus_wdata[31:16]` equals 0x05FA.
- R3: A write with any other value in bits 31:16 leaves the stored state unchanged and raises no request. This includes the readback value 0xFA05.
- R4: Read data bits 31:16 are always 0xFA05. Bit 15 is the endianness flag and is 0, meaning little endian. Bits 14:11 and 7:3 read as 0 whatever was written to them.
- R5: Bits 10:8 hold the grouping field. An accepted write stores `bus_wdata[10:8]` there, and the field reads back in the same bit positions.
- R6: An accepted write with bit 2 set drives `warm_rst_req` high for exactly the one cycle after the write edge. Bit 2 always reads as 0.
- R7: An accepted write with bit 1 set drives `clr_active_req` high for exactly the one cycle after the write edge. Bit 1 always reads as 0.
- R8: An accepted write with bit 0 set drives `core_rst_req` high for one cycle only if `core_halted` is 1 in the write cycle. Otherwise it produces no pulse. Bit 0 always reads as 0.
- R9: `sub_mask` has its lowest (g+1) bits set, where g is the stored grouping value. The mask is capped at `PRIO_W` bits, so g=7 gives 0xFF.
- R10: `bus_rdata` is registered and has one cycle of latency. It returns the register value when `bus_addr` equals `REG_ADDR`, and 0 otherwise. A read in the cycle of an accepted write returns the newly written value. A keyed write to any other address has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, key in bits 31:16 |
| bus_rdata | output | 32 | Registered read data |
| core_halted | input | 1 | Core is halted by debug |
| warm_rst_req | output | 1 | One-cycle warm system reset request |
| clr_active_req | output | 1 | One-cycle clear-active-state request |
| core_rst_req | output | 1 | One-cycle core reset request |
| sub_mask | output | PRIO_W (8) | Subpriority mask derived from the grouping field |

## Verification
A keyed write changes the stored state at its own clock edge. `sub_mask` follows the new grouping value combinationally right after that edge. The request pulses and `bus_rdata` are registered, so they are valid in the cycle after the write edge, and a pulse has dropped again one cycle later. The driver changes inputs on the falling edge and pushes the values due at the next rising edge into a queue. The monitor pops and compares them 5 ns after that rising edge, so every check lands in the one cycle where the result is due, and the following item shows that each pulse has ended.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   // Bit positions decoded by downstream logic and software.
   localparam int KEY_LSB    = 16;
   localparam int KEY_W      = 16;
   localparam int ENDIAN_BIT = 15;
   localparam int GRP_LSB    = 8;
   localparam int GRP_W      = 3;
   localparam int NREQ       = 3;
   // Request bit order: index 0 core reset, 1 clear active, 2 warm reset.
   localparam int REQ_CORE   = 0;
   localparam int REQ_CLR    = 1;
   localparam int REQ_WARM   = 2;

   function automatic logic [KEY_W-1:0] swap_bytes(input logic [KEY_W-1:0] k);
      return {k[7:0], k[15:8]};
   endfunction
endpackage

// File: rtl/sysctl_key_gate.sv
module sysctl_key_gate #(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR = 12'hD0C,
   parameter logic [15:0]       WR_KEY   = 16'h05FA
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [15:0]       key,
   output logic              addr_hit,
   output logic              wr_accept
);
   assign addr_hit  = (addr == REG_ADDR);
   assign wr_accept = wr && addr_hit && (key == WR_KEY);
endmodule

// File: rtl/sysctl_req_pulse.sv
module sysctl_req_pulse #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept,
   input  logic [N-1:0] req_bits,
   input  logic [N-1:0] allow,
   output logic [N-1:0] pulse
);
   for (genvar i = 0; i < N; i++) begin : g_req
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse[i] <= 1'b0;
         else        pulse[i] <= accept & req_bits[i] & allow[i];
      end
   end
endmodule

// File: rtl/sysctl_grp_mask.sv
module sysctl_grp_mask #(
   parameter int GW     = 3,
   parameter int PRIO_W = 8
) (
   input  logic [GW-1:0]     grp,
   output logic [PRIO_W-1:0] mask
);
   for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
      assign mask[i] = (32'(grp) >= i);
   end
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg
   import sysctl_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 12'hD0C,
   parameter logic [15:0]       WR_KEY     = 16'h05FA,
   parameter int                PRIO_W     = 8,
   parameter bit                BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              core_halted,
   output logic              warm_rst_req,
   output logic              clr_active_req,
   output logic              core_rst_req,
   output logic [PRIO_W-1:0] sub_mask
);
   localparam logic [15:0] RD_KEY = swap_bytes(WR_KEY);

   if (PRIO_W < 1 || PRIO_W > 32) begin : g_bad_prio
      $error("sysctl_keyreg: PRIO_W must be 1..32");
   end
   if (REG_ADDR[1:0] != 2'b00) begin : g_bad_addr
      $error("sysctl_keyreg: REG_ADDR must be word aligned");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("sysctl_keyreg: ADDR_W too small");
   end

   logic             addr_hit, wr_accept;
   logic [GRP_W-1:0] grp_q, grp_next;
   logic [NREQ-1:0]  req_bits, allow, pulse;
   logic             endian_bit;
   logic [31:0]      rd_val;
   logic             unused_bits;

   sysctl_key_gate #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY)) u_gate (
      .addr      (bus_addr),
      .wr        (bus_wr),
      .key       (bus_wdata[KEY_LSB +: KEY_W]),
      .addr_hit  (addr_hit),
      .wr_accept (wr_accept)
   );

   assign grp_next = wr_accept ? bus_wdata[GRP_LSB +: GRP_W] : grp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) grp_q <= '0;
      else        grp_q <= grp_next;
   end

   assign req_bits = bus_wdata[NREQ-1:0];
   for (genvar i = 0; i < NREQ; i++) begin : g_allow
      if (i == REQ_CORE) begin : g_halt
         assign allow[i] = core_halted;
      end else begin : g_free
         assign allow[i] = 1'b1;
      end
   end

   sysctl_req_pulse #(.N(NREQ)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (wr_accept),
      .req_bits (req_bits),
      .allow    (allow),
      .pulse    (pulse)
   );

   assign warm_rst_req   = pulse[REQ_WARM];
   assign clr_active_req = pulse[REQ_CLR];
   assign core_rst_req   = pulse[REQ_CORE];

   sysctl_grp_mask #(.GW(GRP_W), .PRIO_W(PRIO_W)) u_mask (
      .grp  (grp_q),
      .mask (sub_mask)
   );

   if (BIG_ENDIAN) begin : g_be
      assign endian_bit = 1'b1;
   end else begin : g_le
      assign endian_bit = 1'b0;
   end

   always_comb begin
      rd_val = '0;
      rd_val[KEY_LSB +: KEY_W]   = RD_KEY;
      rd_val[ENDIAN_BIT]         = endian_bit;
      rd_val[GRP_LSB +: GRP_W]   = grp_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= addr_hit ? rd_val : 32'h0;
   end

   assign unused_bits = ^{bus_wdata[15:11], bus_wdata[7:3]};
endmodule

// File: rtl/sysctl_keyreg_chk.sv
module sysctl_keyreg_chk #(
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] REG_ADDR   = 12'hD0C,
   parameter logic [15:0]       WR_KEY     = 16'h05FA,
   parameter int                PRIO_W     = 8,
   parameter bit                BIG_ENDIAN = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [31:0]       bus_rdata,
   input logic              core_halted,
   input logic              warm_rst_req,
   input logic              clr_active_req,
   input logic              core_rst_req,
   input logic [PRIO_W-1:0] sub_mask
);
   logic keyed;
   assign keyed = bus_wr && (bus_addr == REG_ADDR) && (bus_wdata[31:16] == WR_KEY);

   AST_WARM_FROM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |-> $past(keyed && bus_wdata[2]));                      // R6
   AST_CLR_FROM_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
      clr_active_req |-> $past(keyed && bus_wdata[1]));                    // R7
   AST_CORE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_req |-> $past(keyed && bus_wdata[0] && core_halted));       // R8
   AST_NO_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !keyed |=> $stable(sub_mask));                                       // R3
   AST_UPPER_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata != 32'h0) |-> (bus_rdata[31:15] == {WR_KEY[7:0], WR_KEY[15:8], BIG_ENDIAN})); // R4
   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != REG_ADDR) |=> (bus_rdata == 32'h0));                    // R10
endmodule

bind sysctl_keyreg sysctl_keyreg_chk #(
   .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .WR_KEY(WR_KEY),
   .PRIO_W(PRIO_W), .BIG_ENDIAN(BIG_ENDIAN)
) u_chk (.*);

// File: tb/tb_sysctl_keyreg.sv
module tb_sysctl_keyreg;
   localparam logic [11:0] A = 12'hD0C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        core_halted = 1'b0;
   logic        warm_rst_req, clr_active_req, core_rst_req;
   logic [7:0]  sub_mask;

   always #10 clk = ~clk;

   sysctl_keyreg dut (.*);

   typedef struct {
      logic [31:0] rd;
      logic        w, c, k;
      logic [7:0]  m;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0, n_fail = 0;
   logic [2:0] m_grp = '0;

   function automatic logic [7:0] mask_of(input logic [2:0] g);
      logic [8:0] t;
      t = (9'd1 << (g + 1)) - 9'd1;
      return t[7:0];
   endfunction

   function automatic void check(input string tag, input string what,
                                 input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endfunction

   // Driver: one bus cycle, expected post-edge values pushed to the scoreboard.
   task automatic drive(input string tag, input logic [11:0] addr, input logic wr,
                        input logic [31:0] wd, input logic halted);
      item_t it;
      logic  acc;
      @(negedge clk);
      bus_addr = addr; bus_wr = wr; bus_wdata = wd; core_halted = halted;
      acc = wr && (addr == A) && (wd[31:16] == 16'h05FA);
      if (acc) m_grp = wd[10:8];
      it.rd  = (addr == A) ? {16'hFA05, 1'b0, 4'b0, m_grp, 8'h00} : 32'h0;
      it.w   = acc & wd[2];
      it.c   = acc & wd[1];
      it.k   = acc & wd[0] & halted;
      it.m   = mask_of(m_grp);
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic rd(input string tag);
      drive(tag, A, 1'b0, 32'h0, 1'b0);
   endtask

   // Monitor
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.tag, "rdata", bus_rdata, it.rd);
            check(it.tag, "warm", 32'(warm_rst_req), 32'(it.w));
            check(it.tag, "clr", 32'(clr_active_req), 32'(it.c));
            check(it.tag, "core", 32'(core_rst_req), 32'(it.k));
            check(it.tag, "mask", 32'(sub_mask), 32'(it.m));
         end
      end
   end

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1", "rdata", bus_rdata, 32'h0);
      check("R1", "reqs", {29'h0, warm_rst_req, clr_active_req, core_rst_req}, 32'h0);
      check("R1", "mask", 32'(sub_mask), 32'h01);
      rst_n = 1'b1;
      rd("R1");
      // R2 R5 R9: keyed write of grouping 3
      drive("R2", A, 1'b1, 32'h05FA_0300, 1'b0);
      rd("R5");
      // R3: wrong keys, including the readback value
      drive("R3", A, 1'b1, 32'h05FB_0607, 1'b1);
      drive("R3", A, 1'b1, 32'hFA05_0607, 1'b1);
      rd("R3");
      // R4: reserved and endianness bits written high are not stored
      drive("R4", A, 1'b1, 32'h05FA_FFF8, 1'b0);
      rd("R4");
      drive("R9", A, 1'b1, 32'h05FA_0000, 1'b0);
      // R6 / R7: single-cycle pulses, next item shows them gone
      drive("R6", A, 1'b1, 32'h05FA_0204, 1'b0);
      rd("R6");
      drive("R7", A, 1'b1, 32'h05FA_0202, 1'b0);
      rd("R7");
      // R8: core reset gated by halt
      drive("R8", A, 1'b1, 32'h05FA_0201, 1'b0);
      drive("R8", A, 1'b1, 32'h05FA_0201, 1'b1);
      rd("R8");
      drive("R8", A, 1'b1, 32'h05FA_0507, 1'b1);
      rd("R8");
      // R10: other address ignored and reads 0; same-cycle read of a write
      drive("R10", 12'hD08, 1'b1, 32'h05FA_0107, 1'b1);
      rd("R10");
      drive("R10", 12'h000, 1'b0, 32'h0, 1'b0);
      drive("R10", A, 1'b1, 32'h05FA_0600, 1'b0);
      // R9: every grouping value
      for (int g = 0; g < 8; g++) begin
         drive("R9", A, 1'b1, 32'h05FA_0000 | (32'(g) << 8), 1'b0);
      end
      rd("R9");
      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule